// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps one running 40-bit counter for each frame event of a 10 Gb Ethernet MAC. The receive and transmit datapaths raise one strobe per counter. Frame counters step by one on each strobe. Octet counters step by the byte count that arrives with the strobe: receive-side octet counters take `rx_bytes` and transmit-side octet counters take `tx_bytes`. The default build has 20 counters. Indices 0 to 10 are receive good octets, unicast, multicast, broadcast, pause, FCS errors, symbol errors, over-length frames, jabbers, fragments and undersized frames. Indices 16 to 19 are transmit good octets, unicast, multicast and broadcast. Indices 11 to 15 are spare frame counters.

A host reaches the bank through a plain read/write strobe port. A command write can do two things. It can freeze every live counter into a snapshot register on the same edge, and it can zero the live counters. Counter reads always come from the snapshot, in three narrow words. When a counter carries out of its top bit, it sets a sticky rollover flag. The host polls the flags as four clear-on-read 16-bit words and adds 2^40 to its own copy of the count for each flag it finds set. No interrupt is raised.

Top module: `mac_stat_bank`

## Requirements
- R1: After a synchronous active-low reset, all live counters, snapshots and rollover flags are zero, and `host_rdata` reads zero.
- R2: A frame counter adds exactly 1 on each cycle its strobe is high. A counter whose strobe is low and which receives no clear keeps its value.
- R3: A read at address `{1'b1, n[4:0], w[1:0]}` returns one word of counter n's snapshot on `host_rdata` one cycle after `host_rd`. Word w=0 gives bits 15:0, w=1 gives bits 31:16, and w=2 gives bits 39:32 in bits 7:0 with bits 15:8 zero. Word w=3, counter indices at or above the counter count, and every unmapped address read zero.
- R4: A snap command copies every live counter, as it stood before that edge, into its snapshot on the same edge. Snapshots keep their value until the next snap, whatever the live counters do.
- R5: An octet counter adds the byte count supplied with its strobe in a single cycle. Indices below 16 use `rx_bytes` and the others use `tx_bytes`.
- R6: A clear command sets every live counter to zero and wins over any strobe in the same cycle. Snapshots and rollover flags are left as they were.
- R7: When the addition for counter n carries out of bit 39, rollover flag n is set at bit n mod 16 of rollover word n/16. Rollover word k is read at address 0x10+k.
- R8: Reading a rollover word returns its flags and clears them. A carry that arrives in the same cycle as that read leaves its flag set.
- R9: A write to address 0x00 is the command. `host_wdata` bit 0 requests a snap and bit 1 requests a clear. When both are set, the snapshot receives the values from before the clear.
- R10: `host_rdata` keeps its last value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_strobe | input | NUM_CTR (20) | One event strobe per counter |
| rx_bytes | input | BYTE_W (16) | Byte count for receive-side octet counters |
| tx_bytes | input | BYTE_W (16) | Byte count for transmit-side octet counters |
| host_wr | input | 1 | Command write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 8 | Register address |
| host_wdata | input | 2 | Command bits: bit 0 snap, bit 1 clear |
| host_rdata | output | 16 | Registered read data |

## Verification
Two pairs of functions can land on the same edge. The first pair is a rollover-word read and a fresh carry on a counter that the word covers. The bench drives an octet counter close to 2^40 with maximal byte counts. It then sends the exact remaining count in the same cycle as the read of that rollover word. It expects the read to return the older flags and the following read to show the new flag. The second pair is the command functions against counting. The bench issues a clear while every strobe is high, and issues a combined snap-and-clear. It judges the results by reading snapshots that a reference model predicts as pre-edge values and zeros.

// File: rtl/mac_stat_pkg.sv
// Package: shared constants and the command type for the statistics bank.
// Assumes an 8-bit host address and a 16-bit read word.
package mac_stat_pkg;
    localparam int CTR_W      = 40;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int CMD_W      = 2;
    localparam int ROLL_WORDS = 4;
    localparam int ROLL_BITS  = ROLL_WORDS * DATA_W;
    localparam logic [ADDR_W-1:0] CMD_ADDR  = 8'h00;
    localparam logic [ADDR_W-1:0] ROLL_BASE = 8'h10;

    typedef struct packed {
        logic snap;
        logic clr;
    } stat_cmd_t;
endpackage

// File: rtl/stat_cmd_decode.sv
// Module: decodes host strobes into the snap/clear commands and the
// per-word clear-on-read requests for the rollover flags.
// Assumes host_wr and host_rd are single-cycle strobes.
module stat_cmd_decode
    import mac_stat_pkg::*;
(
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CMD_W-1:0]  host_wdata,
    output stat_cmd_t         cmd,
    output logic [ROLL_WORDS-1:0] roll_rd
);
    // Command register write: bit 0 snap, bit 1 clear.
    always_comb begin
        cmd.snap = host_wr && (host_addr == CMD_ADDR) && host_wdata[0];
        cmd.clr  = host_wr && (host_addr == CMD_ADDR) && host_wdata[1];
    end

    // One-hot request to clear the rollover word being read.
    always_comb begin
        roll_rd = '0;
        if (host_rd && (host_addr[ADDR_W-1:2] == ROLL_BASE[ADDR_W-1:2]))
            roll_rd[host_addr[1:0]] = 1'b1;
    end
endmodule

// File: rtl/stat_counter.sv
// Module: one live statistics counter plus its snapshot register.
// Adds inc on evt, zeroes on clr (clear wins), copies the pre-edge
// value into the snapshot on snap, and pulses wrap on carry-out.
// Assumes INC_W <= CTR_W.
module stat_counter
    import mac_stat_pkg::*;
#(
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [INC_W-1:0] inc,
    input  logic             clr,
    input  logic             snap,
    output logic [CTR_W-1:0] snap_val,
    output logic             wrap
);
    logic [CTR_W-1:0] live;
    logic [CTR_W:0]   sum;

    // Sum with carry bit for rollover detection.
    always_comb sum = {1'b0, live} + (CTR_W+1)'(inc);

    // Carry out of the top bit on an accepted event.
    always_comb wrap = evt && !clr && sum[CTR_W];

    // Live counter update; clear has priority over the event.
    always_ff @(posedge clk) begin
        if (!rst_n)     live <= '0;
        else if (clr)   live <= '0;
        else if (evt)   live <= sum[CTR_W-1:0];
    end

    // Snapshot capture of the pre-edge live value.
    always_ff @(posedge clk) begin
        if (!rst_n)     snap_val <= '0;
        else if (snap)  snap_val <= live;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (live == '0)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !evt) |=> $stable(live)); // R2
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(snap_val)); // R4
endmodule

// File: rtl/stat_rollover.sv
// Module: sticky rollover flags, one per counter, packed into words of
// 16. A read of a word clears it; a wrap in the same cycle survives.
// Flags beyond NUM_CTR read as zero.
module stat_rollover
    import mac_stat_pkg::*;
#(
    parameter int NUM_CTR = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CTR-1:0]    wrap_vec,
    input  logic [ROLL_WORDS-1:0] roll_rd,
    output logic [ROLL_BITS-1:0]  flags
);
    for (genvar i = 0; i < ROLL_BITS; i++) begin : g_flag
        if (i < NUM_CTR) begin : g_live
            logic flag_q;
            // Set on wrap, cleared by a read of its word, set wins.
            always_ff @(posedge clk) begin
                if (!rst_n)                 flag_q <= 1'b0;
                else if (wrap_vec[i])       flag_q <= 1'b1;
                else if (roll_rd[i/DATA_W]) flag_q <= 1'b0;
            end
            assign flags[i] = flag_q;

            AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                wrap_vec[i] |=> flags[i]); // R8
            AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[i] && !roll_rd[i/DATA_W]) |=> flags[i]); // R7
        end else begin : g_none
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/stat_readmux.sv
// Module: registered read multiplexer over snapshots and rollover words.
// Counter region: addr[7]=1, index addr[6:2], word addr[1:0].
// Assumes NUM_CTR <= 32.
module stat_readmux
    import mac_stat_pkg::*;
#(
    parameter int NUM_CTR = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CTR_W-1:0]  snap_arr [NUM_CTR],
    input  logic [ROLL_BITS-1:0] flags,
    output logic [DATA_W-1:0] host_rdata
);
    logic [CTR_W-1:0]  sel;
    logic              sel_ok;
    logic [DATA_W-1:0] rd_next;

    // Pick the addressed snapshot.
    always_comb begin
        sel    = '0;
        sel_ok = 1'b0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (host_addr[6:2] == 5'(i)) begin
                sel    = snap_arr[i];
                sel_ok = 1'b1;
            end
        end
    end

    // Word select across counter, rollover and unmapped regions.
    always_comb begin
        rd_next = '0;
        if (host_addr[7]) begin
            if (sel_ok) begin
                case (host_addr[1:0])
                    2'd0:    rd_next = sel[15:0];
                    2'd1:    rd_next = sel[31:16];
                    2'd2:    rd_next = {8'h00, sel[39:32]};
                    default: rd_next = '0;
                endcase
            end
        end else if (host_addr[ADDR_W-1:2] == ROLL_BASE[ADDR_W-1:2]) begin
            case (host_addr[1:0])
                2'd0:    rd_next = flags[15:0];
                2'd1:    rd_next = flags[31:16];
                2'd2:    rd_next = flags[47:32];
                default: rd_next = flags[63:48];
            endcase
        end
    end

    // Read data register, loaded only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_next;
    end

    AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr[7] && host_addr[1:0] == 2'd2) |=> (host_rdata[15:8] == 8'h00)); // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata)); // R10
endmodule

// File: rtl/mac_stat_bank.sv
// Module: top of the MAC statistics bank. Builds NUM_CTR counters, the
// rollover flag words, command decode and the read multiplexer.
// Octet counters are chosen by OCTET_MASK; indices below TX_BASE take
// rx_bytes, the rest tx_bytes. Assumes NUM_CTR <= 32.
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int          NUM_CTR    = 20,
    parameter int          BYTE_W     = 16,
    parameter int          TX_BASE    = 16,
    parameter logic [63:0] OCTET_MASK = 64'h0000_0000_0001_0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] evt_strobe,
    input  logic [BYTE_W-1:0]  rx_bytes,
    input  logic [BYTE_W-1:0]  tx_bytes,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [7:0]         host_addr,
    input  logic [1:0]         host_wdata,
    output logic [15:0]        host_rdata
);
    stat_cmd_t             cmd;
    logic [ROLL_WORDS-1:0] roll_rd;
    logic [NUM_CTR-1:0]    wrap_vec;
    logic [CTR_W-1:0]      snap_arr [NUM_CTR];
    logic [ROLL_BITS-1:0]  flags;

    stat_cmd_decode u_dec (
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .cmd        (cmd),
        .roll_rd    (roll_rd)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic [BYTE_W-1:0] inc;
        if (OCTET_MASK[i]) begin : g_oct
            if (i < TX_BASE) begin : g_rx
                assign inc = rx_bytes;
            end else begin : g_tx
                assign inc = tx_bytes;
            end
        end else begin : g_frm
            assign inc = BYTE_W'(1);
        end

        stat_counter #(.INC_W(BYTE_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_strobe[i]),
            .inc      (inc),
            .clr      (cmd.clr),
            .snap     (cmd.snap),
            .snap_val (snap_arr[i]),
            .wrap     (wrap_vec[i])
        );
    end

    stat_rollover #(.NUM_CTR(NUM_CTR)) u_roll (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_vec (wrap_vec),
        .roll_rd  (roll_rd),
        .flags    (flags)
    );

    stat_readmux #(.NUM_CTR(NUM_CTR)) u_rmux (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .snap_arr   (snap_arr),
        .flags      (flags),
        .host_rdata (host_rdata)
    );

    AST_RESET_FLAGS_ZERO: assert property (@(posedge clk)
        $rose(rst_n) |-> (flags == '0)); // R1
endmodule

// File: tb/mac_stat_bank_test.sv
// Bench: random event traffic plus directed corner cases, checked
// against a reference model of the requirements kept in the bench.
module mac_stat_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 20;
    localparam int BW         = 32;
    localparam int WD_LIMIT   = 150000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  evt_strobe;
    logic [BW-1:0] rx_bytes, tx_bytes;
    logic          host_wr, host_rd;
    logic [7:0]    host_addr;
    logic [1:0]    host_wdata;
    logic [15:0]   host_rdata;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [39:0] m_live [N];
    logic [39:0] m_snap [N];
    logic [63:0] m_roll;
    logic [15:0] exp_rd;
    logic [15:0] got_rd;

    mac_stat_bank #(.NUM_CTR(N), .BYTE_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
        .rx_bytes(rx_bytes), .tx_bytes(tx_bytes),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_octet(int i);
        return (i == 0) || (i == 16);
    endfunction

    function automatic logic [15:0] model_read(logic [7:0] a);
        int idx = int'(a[6:2]);
        if (a[7]) begin
            if (idx >= N) return 16'h0;
            case (a[1:0])
                2'd0: return m_snap[idx][15:0];
                2'd1: return m_snap[idx][31:16];
                2'd2: return {8'h00, m_snap[idx][39:32]};
                default: return 16'h0;
            endcase
        end
        if (a[7:2] == 6'h04) return m_roll[int'(a[1:0])*16 +: 16];
        return 16'h0;
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One clock: drive at negedge, update model, sample after posedge.
    task automatic apply(logic [N-1:0] st, logic [BW-1:0] rb, logic [BW-1:0] tb,
                         logic wr, logic [1:0] wd, logic rd, logic [7:0] ad);
        logic snap, clr;
        logic [40:0] s;
        evt_strobe = st; rx_bytes = rb; tx_bytes = tb;
        host_wr = wr; host_wdata = wd; host_rd = rd; host_addr = ad;
        snap = wr && ad == 8'h00 && wd[0];
        clr  = wr && ad == 8'h00 && wd[1];
        if (rd) begin
            exp_rd = model_read(ad);
            if (ad[7:2] == 6'h04) m_roll[int'(ad[1:0])*16 +: 16] = 16'h0;
        end
        for (int i = 0; i < N; i++) begin
            if (snap) m_snap[i] = m_live[i];
            if (clr) m_live[i] = '0;
            else if (st[i]) begin
                s = {1'b0, m_live[i]} + (is_octet(i) ? 41'(i < 16 ? rb : tb) : 41'd1);
                if (s[40]) m_roll[i] = 1'b1;
                m_live[i] = s[39:0];
            end
        end
        @(posedge clk); #1;
        got_rd = host_rdata;
        @(negedge clk);
        evt_strobe = '0; host_wr = 0; host_rd = 0;
    endtask

    task automatic idle();
        apply('0, '0, '0, 0, 2'b00, 0, 8'h00);
    endtask

    task automatic rd_check(string req, logic [7:0] a);
        apply('0, '0, '0, 0, 2'b00, 1, a);
        check(req, got_rd, exp_rd);
    endtask

    task automatic snap_and_read_all(string req);
        apply('0, '0, '0, 1, 2'b01, 0, 8'h00);
        for (int i = 0; i < N; i++)
            for (int w = 0; w < 3; w++)
                rd_check(req, {1'b1, 5'(i), 2'(w)});
    endtask

    // Bring octet counter k to exactly 2^40 with a rollover read in the final cycle.
    task automatic wrap_octet(int k, logic [7:0] roll_addr);
        logic [40:0] rem;
        logic [N-1:0] st;
        st = '0; st[k] = 1'b1;
        rem = 41'h100_0000_0000 - {1'b0, m_live[k]};
        while (rem > 41'h0_FFFF_FFFF) begin
            if (k < 16) apply(st, 32'hFFFF_FFFF, '0, 0, 2'b00, 0, 8'h00);
            else        apply(st, '0, 32'hFFFF_FFFF, 0, 2'b00, 0, 8'h00);
            rem = 41'h100_0000_0000 - {1'b0, m_live[k]};
        end
        if (k < 16) apply(st, rem[31:0], '0, 0, 2'b00, 1, roll_addr);
        else        apply(st, '0, rem[31:0], 0, 2'b00, 1, roll_addr);
        check("R8 same-cycle read returns older flags", got_rd, exp_rd);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog (all requirements): cycles %0d expected < %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] st;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin m_live[i] = '0; m_snap[i] = '0; end
        m_roll = '0;
        rst_n = 0; evt_strobe = '0; rx_bytes = '0; tx_bytes = '0;
        host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        check("R1 rdata after reset", host_rdata, 16'h0);

        // R1: snapshots and rollover words read zero after reset
        rd_check("R1 snapshot ctr0 word0", 8'h80);
        rd_check("R1 rollover word0", 8'h10);
        rd_check("R1 rollover word1", 8'h11);

        // R2/R5: random traffic at three densities, then snap and read all (R3, R4)
        for (int round = 0; round < 3; round++) begin
            for (int c = 0; c < 40; c++) begin
                st = N'($urandom);
                if (round == 0) st = st & N'($urandom) & N'($urandom);
                if (round == 2) st = st | N'($urandom);
                apply(st, BW'($urandom % 1600), BW'($urandom % 9600), 0, 2'b00, 0, 8'h00);
            end
            snap_and_read_all(round == 1 ? "R5 octet and frame counts" : "R2 counts via snapshot R3");
        end

        // R4: snapshots hold while live counters keep running
        for (int c = 0; c < 10; c++) apply('1, BW'(100), BW'(200), 0, 2'b00, 0, 8'h00);
        rd_check("R4 snapshot holds ctr1", 8'h84);
        rd_check("R4 snapshot holds ctr16 hi", 8'hC1);

        // R4: snap in the same cycle as events takes pre-edge values
        apply('1, BW'(7), BW'(9), 1, 2'b01, 0, 8'h00);
        rd_check("R4 snap with event ctr2", 8'h88);
        rd_check("R4 snap with event ctr0", 8'h80);

        // R3: word 3, out-of-range counter and unmapped address read zero
        rd_check("R3 word3 zero", 8'h83);
        rd_check("R3 index beyond count", {1'b1, 5'd25, 2'd0});
        rd_check("R3 unmapped address", 8'h24);

        // R10: rdata holds through idle cycles
        rd_check("R10 setup read", 8'h84);
        idle(); idle();
        check("R10 rdata hold", host_rdata, exp_rd);

        // R6: clear with all strobes high; snapshot untouched, live zero
        apply('1, BW'(55), BW'(66), 1, 2'b10, 0, 8'h00);
        rd_check("R6 snapshot untouched by clear", 8'h84);
        snap_and_read_all("R6 clear wins over events");

        // R9: snap and clear together
        for (int c = 0; c < 5; c++) apply('1, BW'(3), BW'(4), 0, 2'b00, 0, 8'h00);
        apply('0, '0, '0, 1, 2'b11, 0, 8'h00);
        rd_check("R9 combined command snapshot pre-clear", 8'h84);
        rd_check("R9 combined command ctr16", 8'hC0);
        snap_and_read_all("R9 live zero after combined command");

        // R7/R8: rx octet counter 0 wraps with same-cycle read of word 0
        wrap_octet(0, 8'h10);
        rd_check("R7 flag ctr0 at word0 bit0", 8'h10);
        rd_check("R8 clear-on-read word0", 8'h10);
        // tx octet counter 16 lands in word 1 bit 0
        wrap_octet(16, 8'h11);
        rd_check("R7 flag ctr16 at word1 bit0", 8'h11);
        rd_check("R8 clear-on-read word1", 8'h11);
        rd_check("R7 word0 unaffected", 8'h10);
        apply('0, '0, '0, 1, 2'b01, 0, 8'h00);
        rd_check("R7 wrapped counter reads zero", 8'h80);
        rd_check("R7 wrapped counter16 top", 8'hC2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule